// File: doc/BRIEF.md
# Reset Release and Strap Controller

This block sits on the device reference clock and takes over once the power-on reset has been released. It first drives the boot-configuration straps. It then keeps the full-reset line low for a window measured in clock transitions, counting both edges of the clock. After that it raises full reset and keeps the straps valid for a further window. Only then does it turn the strap drivers off so the pins go to high impedance.

After the straps are released, the block watches the device's reset-status line through a synchronizer. It reports completion when that line goes high. It raises a sticky timeout if the line stays low past the longest allowed initialization time plus a margin. It raises a warning flag if the line goes high sooner than the shortest expected initialization time.

A drop of the power-on-released flag at any point sends the block back to idle. In idle, full reset is low and the straps are driven again.

Top module: `rst_boot_ctrl`

## Requirements
- R1: While `rst_ni` is low, `full_rst_no` is low, `strap_oe_o` is high, `strap_o` is zero, and `done_o`, `timeout_o` and `early_o` are low.
- R2: While `por_ok_i` is low, `full_rst_no` is low, `strap_oe_o` is high, and `strap_o` shows the `strap_val_i` value sampled at the previous rising edge.
- R3: Take the first rising edge at which `por_ok_i` is sampled high. `full_rst_no` stays low for LOW_CYC cycles after that edge and then rises. LOW_CYC = max(ceil(RST_EDGES/2), ceil(SETUP_EDGES/2)) + MARGIN_CYC, which is 14 with the default values.
- R4: `strap_o` keeps the value sampled at that first high edge, and ignores any change of `strap_val_i`, until `por_ok_i` goes low.
- R5: `strap_oe_o` stays high for HOLD_CYC = ceil(HOLD_EDGES/2) + MARGIN_CYC cycles after `full_rst_no` rises, then goes low. It is never low while `full_rst_no` is low.
- R6: `rst_stat_i` passes through a two-flop synchronizer. Once the straps are released, `done_o` rises at the third rising edge after `rst_stat_i` goes high.
- R7: `done_o` stays high, whatever `rst_stat_i` does, until `por_ok_i` goes low.
- R8: If the synchronized status is still low when TOUT_CYC = STAT_MAX_CYC + STAT_MARGIN_CYC cycles have passed since `full_rst_no` rose, `timeout_o` is set. It stays set until `por_ok_i` goes low, and in that time `done_o` never rises.
- R9: `early_o` is set together with `done_o` when the synchronized status is seen high fewer than STAT_MIN_CYC cycles after `full_rst_no` rose. It is never high without `done_o`.
- R10: If the synchronized status is high at the very edge where the timeout limit is reached, `done_o` is set and `timeout_o` is not.
- R11: A low `por_ok_i` at any rising edge returns the block to idle on that edge. `full_rst_no` goes low, `strap_oe_o` goes high, and `done_o`, `timeout_o` and `early_o` are cleared.
- R12: A high `rst_stat_i` while full reset is low or the straps are still driven does not set `done_o`. It is first acted on once the strap hold window has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_ok_i | input | 1 | Power-on reset released and stable |
| strap_val_i | input | STRAP_W | Boot-configuration strap word to apply |
| rst_stat_i | input | 1 | Reset-status line from the device (asynchronous) |
| full_rst_no | output | 1 | Full reset to the device, active low |
| strap_o | output | STRAP_W | Strap data to the pins |
| strap_oe_o | output | 1 | Strap pin output enable |
| done_o | output | 1 | Device reported initialization complete |
| timeout_o | output | 1 | Initialization did not complete in time (sticky) |
| early_o | output | 1 | Status came back sooner than expected |

## Verification
The status arrival and the timeout expiry can be decided at the same clock edge. The bench provokes this by raising `rst_stat_i` exactly two edges before the limit edge, counted from the cycle in which full reset is first seen high. It then expects `done_o` set and `timeout_o` clear. A second run raises the status one cycle later and expects the timeout instead. A behavioural cycle model, kept as phase and counter integers, judges every output on every clock. This covers power-on drops in the middle of the reset window as well.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HOLD, ST_WAIT, ST_DONE, ST_TOUT
  } rbc_state_e;

  // both clock edges count, so N transitions need ceil(N/2) cycles
  function automatic int unsigned edges_to_cycles(int unsigned edges, int unsigned margin);
    return (edges + 1) / 2 + margin;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rbc_sync.sv
module rbc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rbc_strap_reg.sv
module rbc_strap_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/rbc_seq.sv
module rbc_seq
  import rbc_pkg::*;
#(
  parameter int unsigned LOW_CYC  = 14,
  parameter int unsigned HOLD_CYC = 8,
  parameter int unsigned STAT_MIN = 10000,
  parameter int unsigned TOUT_CYC = 51000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ok_i,
  input  logic stat_i,
  output logic load_strap_o,
  output logic full_rst_no,
  output logic strap_oe_o,
  output logic done_o,
  output logic timeout_o,
  output logic early_o
);
  localparam int unsigned CNT_MAX = max_u(max_u(LOW_CYC, HOLD_CYC), TOUT_CYC);
  localparam int unsigned CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] TOUT_LAST = CW'(TOUT_CYC - 1);
  localparam logic [CW-1:0] MIN_C     = CW'(STAT_MIN);

  rbc_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic early_q, early_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    early_d = early_q;
    if (!por_ok_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      early_d = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          state_d = ST_LOW;
          cnt_d   = '0;
        end
        ST_LOW: begin
          if (cnt_q == LOW_LAST) begin
            state_d = ST_HOLD;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          // counter keeps running: it measures time since full reset rose
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == HOLD_LAST) state_d = ST_WAIT;
        end
        ST_WAIT: begin
          if (stat_i) begin           // status wins over a coincident timeout
            state_d = ST_DONE;
            early_d = (cnt_q < MIN_C);
          end else if (cnt_q == TOUT_LAST) begin
            state_d = ST_TOUT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      early_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      early_q <= early_d;
    end
  end

  assign load_strap_o = !por_ok_i || (state_q == ST_IDLE);
  assign full_rst_no  = state_q inside {ST_HOLD, ST_WAIT, ST_DONE, ST_TOUT};
  assign strap_oe_o   = state_q inside {ST_IDLE, ST_LOW, ST_HOLD};
  assign done_o       = (state_q == ST_DONE);
  assign timeout_o    = (state_q == ST_TOUT);
  assign early_o      = early_q;
endmodule

// File: rtl/rst_boot_ctrl.sv
module rst_boot_ctrl
  import rbc_pkg::*;
#(
  parameter int unsigned STRAP_W         = 16,
  parameter int unsigned RST_EDGES       = 24,
  parameter int unsigned SETUP_EDGES     = 12,
  parameter int unsigned HOLD_EDGES      = 12,
  parameter int unsigned MARGIN_CYC      = 2,
  parameter int unsigned STAT_MIN_CYC    = 10000,
  parameter int unsigned STAT_MAX_CYC    = 50000,
  parameter int unsigned STAT_MARGIN_CYC = 1000,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_ok_i,
  input  logic [STRAP_W-1:0] strap_val_i,
  input  logic               rst_stat_i,
  output logic               full_rst_no,
  output logic [STRAP_W-1:0] strap_o,
  output logic               strap_oe_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic               early_o
);
  // reset low window must cover both the reset rule and the strap setup rule
  localparam int unsigned LOW_CYC  = max_u(edges_to_cycles(RST_EDGES, MARGIN_CYC),
                                           edges_to_cycles(SETUP_EDGES, MARGIN_CYC));
  localparam int unsigned HOLD_CYC = edges_to_cycles(HOLD_EDGES, MARGIN_CYC);
  localparam int unsigned TOUT_CYC = STAT_MAX_CYC + STAT_MARGIN_CYC;

  logic stat_sync;
  logic load_strap;

  rbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rst_stat_i),
    .q_o   (stat_sync)
  );

  rbc_strap_reg #(.W(STRAP_W)) u_strap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_strap),
    .d_i   (strap_val_i),
    .q_o   (strap_o)
  );

  rbc_seq #(
    .LOW_CYC (LOW_CYC),
    .HOLD_CYC(HOLD_CYC),
    .STAT_MIN(STAT_MIN_CYC),
    .TOUT_CYC(TOUT_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .por_ok_i    (por_ok_i),
    .stat_i      (stat_sync),
    .load_strap_o(load_strap),
    .full_rst_no (full_rst_no),
    .strap_oe_o  (strap_oe_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .early_o     (early_o)
  );
endmodule

// File: rtl/rst_boot_ctrl_chk.sv
module rst_boot_ctrl_chk #(
  parameter int unsigned STRAP_W = 16,
  parameter int unsigned LOW_CYC = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               por_ok_i,
  input logic               rst_stat_i,
  input logic               full_rst_no,
  input logic [STRAP_W-1:0] strap_o,
  input logic               strap_oe_o,
  input logic               done_o,
  input logic               timeout_o,
  input logic               early_o
);
  int unsigned lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      lo_cnt <= 0;
    else if (!por_ok_i || full_rst_no) lo_cnt <= 0;
    else if (lo_cnt != '1)            lo_cnt <= lo_cnt + 1;
  end

  // R3
  low_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_rst_no) |-> lo_cnt >= LOW_CYC);

  // R4
  strap_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_rst_no && $past(full_rst_no)) |-> $stable(strap_o));

  // R5
  oe_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strap_oe_o |-> full_rst_no);

  // R6
  done_from_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(rst_stat_i, 3));

  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && por_ok_i) |=> done_o);

  // R8
  timeout_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && por_ok_i) |=> (timeout_o && !done_o));

  // R9
  early_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early_o |-> done_o);

  // R11
  por_drop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> (!full_rst_no && strap_oe_o && !done_o && !timeout_o && !early_o));
endmodule

bind rst_boot_ctrl rst_boot_ctrl_chk #(
  .STRAP_W(STRAP_W),
  .LOW_CYC(LOW_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_ok_i   (por_ok_i),
  .rst_stat_i (rst_stat_i),
  .full_rst_no(full_rst_no),
  .strap_o    (strap_o),
  .strap_oe_o (strap_oe_o),
  .done_o     (done_o),
  .timeout_o  (timeout_o),
  .early_o    (early_o)
);

// File: tb/rst_boot_ctrl_bench.sv
`timescale 1ns/1ps
module rst_boot_ctrl_bench;
  localparam int W = 8;
  localparam int LOW = 14;   // ceil(24/2)+2
  localparam int HOLD = 8;   // ceil(12/2)+2
  localparam int SMIN = 100;
  localparam int TOUT = 450; // 400 + 50

  logic clk = 1'b0, rst_n = 1'b0, por = 1'b0, stat = 1'b0;
  logic [W-1:0] sv = '0;
  logic full_rst_n, oe, done, tout, early;
  logic [W-1:0] strap;

  always #2.5 clk = ~clk;

  rst_boot_ctrl #(
    .STRAP_W(W), .RST_EDGES(24), .SETUP_EDGES(12), .HOLD_EDGES(12), .MARGIN_CYC(2),
    .STAT_MIN_CYC(SMIN), .STAT_MAX_CYC(400), .STAT_MARGIN_CYC(50), .SYNC_STAGES(2)
  ) u_rst_boot_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .por_ok_i(por), .strap_val_i(sv), .rst_stat_i(stat),
    .full_rst_no(full_rst_n), .strap_o(strap), .strap_oe_o(oe), .done_o(done),
    .timeout_o(tout), .early_o(early)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk1(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkv(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chki(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // behavioural reference: phase 0 idle, 1 running, 2 done, 3 timed out
  int m_ph = 0, m_t = 0;
  logic [W-1:0] m_strap = '0;
  logic m_early = 1'b0;
  logic [1:0] m_sync = '0;

  always @(posedge clk) begin
    logic s_old;
    int prev_t;
    if (!rst_n) begin
      m_ph = 0; m_t = 0; m_strap = '0; m_early = 1'b0; m_sync = '0;
    end else begin
      s_old  = m_sync[1];
      m_sync = {m_sync[0], stat};
      if (!por) begin
        m_ph = 0; m_strap = sv; m_early = 1'b0;
      end else if (m_ph == 0) begin
        m_ph = 1; m_t = 0; m_strap = sv;
      end else if (m_ph == 1) begin
        prev_t = m_t;
        m_t = m_t + 1;
        if (prev_t >= LOW + HOLD) begin
          if (s_old) begin
            m_ph = 2; m_early = ((prev_t - LOW) < SMIN);
          end else if (prev_t - LOW == TOUT - 1) begin
            m_ph = 3;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk1("R3 full reset model", full_rst_n, (m_ph >= 2) || (m_ph == 1 && m_t >= LOW));
      chkv("R4 strap model", strap, m_strap);
      chk1("R5 strap enable model", oe, (m_ph == 0) || (m_ph == 1 && m_t < LOW + HOLD));
      chk1("R6 done model", done, m_ph == 2);
      chk1("R8 timeout model", tout, m_ph == 3);
      chk1("R9 early model", early, m_early);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  // drive por high and return the cycle count until full reset is seen high
  task automatic start_and_rise(input logic [W-1:0] val, output int cyc);
    sv = val; por = 1'b1; cyc = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); cyc++;
      if (cyc == 2) sv = ~val;
      if (full_rst_n) break;
    end
  endtask

  task automatic go_idle;
    por = 1'b0; stat = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    chk1("R1 full reset", full_rst_n, 1'b0);
    chk1("R1 oe", oe, 1'b1);
    chkv("R1 strap", strap, '0);
    chk1("R1 done", done, 1'b0);
    chk1("R1 timeout", tout, 1'b0);
    chk1("R1 early", early, 1'b0);
    rst_n = 1'b1;

    sv = 8'h3C; @(negedge clk);
    chkv("R2 strap follows idle", strap, 8'h3C);
    sv = 8'hA5; @(negedge clk);
    chkv("R2 strap follows idle", strap, 8'hA5);
    chk1("R2 full reset low", full_rst_n, 1'b0);
    chk1("R2 oe high", oe, 1'b1);

    // normal run
    start_and_rise(8'h5A, c);
    chki("R3 low window cycles", c, LOW + 1);
    chkv("R4 strap frozen", strap, 8'h5A);
    c = 0;
    for (int i = 0; i < 100 && oe; i++) begin @(negedge clk); c++; end
    chki("R5 hold cycles", c, HOLD);
    repeat (150) @(negedge clk);
    stat = 1'b1;
    @(negedge clk); @(negedge clk);
    chk1("R6 done not yet", done, 1'b0);
    @(negedge clk);
    chk1("R6 done third edge", done, 1'b1);
    chk1("R9 no early", early, 1'b0);
    stat = 1'b0;
    repeat (5) @(negedge clk);
    chk1("R7 done sticky", done, 1'b1);
    por = 1'b0; @(negedge clk);
    chk1("R11 full reset low", full_rst_n, 1'b0);
    chk1("R11 oe high", oe, 1'b1);
    chk1("R11 done cleared", done, 1'b0);
    go_idle();

    // status high from the start: ignored until straps released, then early
    stat = 1'b1;
    start_and_rise(8'h11, c);
    for (int i = 0; i < 100 && oe; i++) begin
      chk1("R12 done held off", done, 1'b0);
      @(negedge clk);
    end
    chk1("R12 done off at release", done, 1'b0);
    @(negedge clk);
    chk1("R12 done after release", done, 1'b1);
    chk1("R9 early set", early, 1'b1);
    go_idle();
    chk1("R11 early cleared", early, 1'b0);

    // timeout
    start_and_rise(8'h22, c);
    c = 0;
    for (int i = 0; i < TOUT + 10 && !tout; i++) begin @(negedge clk); c++; end
    chki("R8 timeout cycles", c, TOUT);
    stat = 1'b1;
    repeat (5) @(negedge clk);
    chk1("R8 timeout sticky", tout, 1'b1);
    chk1("R8 no late done", done, 1'b0);
    go_idle();
    chk1("R11 timeout cleared", tout, 1'b0);

    // status and limit on the same edge: done wins
    start_and_rise(8'h33, c);
    repeat (TOUT - 3) @(negedge clk);
    stat = 1'b1;
    repeat (5) @(negedge clk);
    chk1("R10 done wins", done, 1'b1);
    chk1("R10 no timeout", tout, 1'b0);
    go_idle();

    // one cycle later: timeout wins
    start_and_rise(8'h44, c);
    repeat (TOUT - 2) @(negedge clk);
    stat = 1'b1;
    repeat (5) @(negedge clk);
    chk1("R8 late status timeout", tout, 1'b1);
    chk1("R8 late status no done", done, 1'b0);
    go_idle();

    // power-on drop inside the low window, then restart
    sv = 8'h66; por = 1'b1;
    repeat (5) @(negedge clk);
    sv = 8'h77; por = 1'b0;
    @(negedge clk);
    chk1("R11 drop mid window", full_rst_n, 1'b0);
    chkv("R2 strap reloads", strap, 8'h77);
    start_and_rise(8'h88, c);
    chki("R3 restart window", c, LOW + 1);
    chkv("R4 restart strap", strap, 8'h88);
    go_idle();

    report();
  end
endmodule